// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the timing controller for a 10-bit successive-approximation conversion. It runs on its own free-running conversion clock, which is separate from the serial port clock. A start request comes from the serial domain at the end of analog sampling. The block passes it through a two-flop synchronizer and a rising-edge detector. It then raises a busy status for a fixed window of 41 conversion-clock cycles.

Inside that window the block runs the bit trials from the MSB down to the LSB. Each trial sets the bit under test in the trial code. That code drives the DAC. The combined DAC and comparator is modelled as one input bit, `cmpIn`. At the end of the trial the block keeps the bit or clears it, based on that input. In the last busy cycle a one-cycle strobe tells the output shift register to load the final code. Busy then drops, and a new conversion may start.

Top module: `sar_seq_top`

## Requirements
- R1: A rising edge on `startReq` starts a conversion. When `startReq` changes just after a clock edge, `busy` rises at the third rising edge of `clk` after that change.
- R2: `busy` stays high for exactly 41 consecutive clock cycles. It is low in the cycle that follows them.
- R3: In the first busy cycle, `code` holds only bit 9 set (value 512). A trial keeps its bit when `cmpIn` is 1 and clears it when `cmpIn` is 0.
- R4: Suppose `cmpIn` is 1 exactly when `code` is less than or equal to an input value V, where V is in 0..1023. Then `code` equals V during the last busy cycle.
- R5: `loadStb` is high only in the last (41st) busy cycle, for a single cycle.
- R6: A rising edge on `startReq` while `busy` is high is ignored. The window is not lengthened, the result is not changed, and no new conversion follows.
- R7: While `rstN` is low, `busy` and `loadStb` are low and `code` is 0.
- R8: After a conversion ends, `code` keeps the result until the next conversion starts.
- R9: Number the busy cycles c = 0..40 and let k = 0..9. The trial of bit 9-k takes cycles 4k to 4k+3. Its decision is taken at the clock edge that ends cycle 4k+3. At that same edge the next lower bit is set for its own trial. Cycle 40 carries no trial.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running conversion clock |
| rstN | input | 1 | Active-low reset |
| startReq | input | 1 | Start request from the serial domain, asynchronous to `clk` |
| cmpIn | input | 1 | Comparator result for the current trial code: 1 means keep the bit |
| busy | output | 1 | Conversion in progress |
| loadStb | output | 1 | One-cycle load strobe for the output shift register |
| code | output | 10 | Trial code for the DAC during a conversion; the result afterwards |

## Verification
The assertions assume that `startReq` is a level from another clock domain. They assume it stays low for at least two clock cycles before each new rising edge, so that the edge detector sees every request. They also assume `cmpIn` is a clean bit that is valid at each sampling edge. The bench keeps to both assumptions. It changes `startReq` only on falling clock edges, with low gaps of several cycles. It drives `cmpIn` combinationally from `code` against a fixed input value. That value is swept over all 1024 codes, and every seventh sweep point gets an extra start pulse in the middle of its window.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef struct packed {
    logic start;
    logic decide;
  } sarStrobe_t;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS    = 10,
  parameter int BUSY_CYCLES = 41
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  output logic       busy,
  output logic       loadStb,
  output sarStrobe_t strobe
);
  localparam int STEP = (BUSY_CYCLES - 1) / RES_BITS;
  localparam int CW   = $clog2(BUSY_CYCLES + 1);
  localparam int PW   = (STEP > 1) ? $clog2(STEP) : 1;
  localparam logic [CW-1:0] LAST      = CW'(BUSY_CYCLES - 1);
  localparam logic [CW-1:0] TRIAL_END = CW'(RES_BITS * STEP);
  localparam logic [PW-1:0] PH_LAST   = PW'(STEP - 1);

  logic syncA, syncB, syncC, reqRise;
  logic [CW-1:0] cnt;
  logic [PW-1:0] phase;

  assign reqRise = syncB & ~syncC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
      busy  <= 1'b0;
      cnt   <= '0;
      phase <= '0;
    end else begin
      syncA <= startReq;
      syncB <= syncA;
      syncC <= syncB;
      if (!busy) begin
        if (reqRise) begin
          busy  <= 1'b1;
          cnt   <= '0;
          phase <= '0;
        end
      end else begin
        if (cnt == LAST) busy <= 1'b0;
        else             cnt  <= cnt + 1'b1;
        phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      end
    end
  end

  assign loadStb       = busy && (cnt == LAST);
  assign strobe.start  = !busy && reqRise;
  assign strobe.decide = busy && (phase == PH_LAST) && (cnt < TRIAL_END);

  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy && !loadStb |=> busy);
  p_load_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> !busy);
  p_start_sync_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(syncB) && !$past(syncC));
  p_ignore_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy && reqRise && !loadStb |=> busy && cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  sarStrobe_t          strobe,
  input  logic                cmpIn,
  output logic [RES_BITS-1:0] code
);
  localparam logic [RES_BITS-1:0] MSB = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] sar, trialMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sar       <= '0;
      trialMask <= '0;
    end else if (strobe.start) begin
      sar       <= MSB;
      trialMask <= MSB;
    end else if (strobe.decide) begin
      sar       <= (cmpIn ? sar : (sar & ~trialMask)) | (trialMask >> 1);
      trialMask <= trialMask >> 1;
    end
  end

  assign code = sar;

  p_start_msb_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> code == MSB);
  p_keep_bit_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decide && cmpIn |=> (code & $past(trialMask)) != '0);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.start && !strobe.decide |=> $stable(code));
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS    = 10,
  parameter int BUSY_CYCLES = 41
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                cmpIn,
  output logic                busy,
  output logic                loadStb,
  output logic [RES_BITS-1:0] code
);
  sarStrobe_t strobe;

  sar_seq_ctrl #(.RES_BITS(RES_BITS), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .busy(busy), .loadStb(loadStb), .strobe(strobe)
  );

  sar_seq_dp #(.RES_BITS(RES_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpIn(cmpIn), .code(code)
  );
endmodule

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN, startReq;
  logic busy, loadStb, cmpIn;
  logic [9:0] code;
  int vin;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmpIn = (int'(code) <= vin);

  sar_seq_top dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmpIn(cmpIn),
    .busy(busy), .loadStb(loadStb), .code(code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCode(input int v, input int c);
    int k = c / 4;
    if (k >= 10) return v;
    return (v & ~((1 << (10 - k)) - 1) & 32'h3FF) | (1 << (9 - k));
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic convert(input int v, input bit glitch);
    vin = v;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R1 early", int'(busy), 0);
    @(negedge clk);
    chk(busy == 1'b1, "R1 rise", int'(busy), 1);
    for (int c = 0; c <= 40; c++) begin
      if (c > 0) @(negedge clk);
      chk(busy == 1'b1, "R2 busy", int'(busy), 1);
      chk(loadStb == (c == 40), "R5 strobe", int'(loadStb), int'(c == 40));
      chk(int'(code) == expCode(v, c), "R9 R3 trial", int'(code), expCode(v, c));
      if (c == 40) chk(int'(code) == v, "R4 result", int'(code), v);
      if (c == 5) startReq = 1'b0;
      if (glitch && c == 12) startReq = 1'b1;
      if (glitch && c == 20) startReq = 1'b0;
    end
    @(negedge clk);
    chk(busy == 1'b0, "R2 fall", int'(busy), 0);
    for (int i = 0; i < (glitch ? 4 : 2); i++) begin
      @(negedge clk);
      if (glitch) chk(busy == 1'b0, "R6 ignored", int'(busy), 0);
      chk(int'(code) == v, "R8 hold", int'(code), v);
    end
  endtask

  initial begin
    rstN = 1'b0;
    startReq = 1'b0;
    vin = 0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R7 busy", int'(busy), 0);
    chk(loadStb == 1'b0, "R7 strobe", int'(loadStb), 0);
    chk(code == 10'd0, "R7 code", int'(code), 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 1024; v++) convert(v, (v % 7) == 3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule